// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the byte stream of incoming Ethernet frames and decides, from the six-byte destination address at the head of each frame, whether the frame should be kept. A byte is taken on every cycle with `in_vld` high. The byte that carries `in_sof` is byte 0 of a new frame. In the cycle after the sixth destination byte the block raises `dec_valid` for one cycle, together with an accept flag and a reason code.

Software programs the filter through a write-only port of 16-bit registers. Address 0 holds the configuration bits. Addresses 1 to 3 hold the station address. Addresses 4 to 7 hold a 64-bit multicast hash table. A frame is accepted, in order of precedence, because the filter is promiscuous, because the destination equals the station address, because it is broadcast, or because its hash bit is set. The downstream frame store uses the decision to keep or discard the frame.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset `dec_valid`, `dec_accept` and `dec_reason` are low and every configuration register is zero, so the first frame sent is rejected with reason 0.
- R2: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth valid destination byte. Idle cycles between valid bytes are allowed. Valid bytes after the sixth produce no further decision until the next `in_sof`.
- R3: When the receive-enable bit (bit 0 of address 0) is clear, every decision carries reason 0 (reject).
- R4: When receive enable and the promiscuous bit (bit 1 of address 0) are both set, every decision carries reason 4, whatever the address.
- R5: The station-address registers are at addresses 1, 2 and 3, one per word k = 0, 1, 2. Destination byte 2k must equal bits [15:8] of word k and byte 2k+1 must equal bits [7:0]. A full match gives reason 1 and takes precedence over broadcast and hash.
- R6: A destination of six 0xFF bytes that does not match the station address gives reason 2.
- R7: The hash table is consulted only when the hash-enable bit (bit 2 of address 0) is set and both the station and broadcast checks have failed. When it is not consulted, such a frame gets reason 0.
- R8: The hash index is bits [31:26] of a CRC-32 over the six destination bytes. The CRC is taken least significant bit first, with reflected polynomial 0xEDB88320, an all-ones start value and no final inversion.
- R9: Hash index bits [5:4] select table word k, which is written at address 7-k. Index bits [3:0] select the bit within that word. A set bit gives reason 3 and a clear bit gives reason 0.
- R10: An `in_sof` with `in_vld` abandons any partial address and starts a new one, with that byte as byte 0.
- R11: `dec_accept` is high exactly when `dec_reason` is nonzero. Reason codes never exceed 4, and all decision outputs are zero while `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 config, 1-3 station, 4-7 hash) |
| wr_data | input | 16 | Register write data |
| in_vld | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of a frame (qualified by in_vld) |
| in_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 station, 2 broadcast, 3 hash, 4 promiscuous |

## Verification
The assertions assume that no register is written while a frame's sixth byte is in flight, because the decision samples the configuration in that cycle. They also assume the default six-byte address, so two decisions can never fall in adjacent cycles. The bench changes configuration only between frames and always drives at least six bytes before it expects a decision. The hash table is loaded through the write port, and the bench derives each expected reason from its own bit-serial CRC model.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int DEST_BYTES = 6,
  parameter int WORD_W     = 16,
  parameter int HASH_WORDS = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic [7:0]        in_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_reason
);
  localparam int CNT_W     = $clog2(DEST_BYTES + 1);
  localparam int STA_WORDS = DEST_BYTES * 8 / WORD_W;
  localparam int TAB_BITS  = HASH_WORDS * WORD_W;
  localparam int IDX_W     = $clog2(TAB_BITS);
  localparam int STA_BASE  = 1;
  localparam int HASH_TOP  = STA_BASE + STA_WORDS + HASH_WORDS - 1;
  localparam logic [31:0] POLY = 32'hEDB88320;

  localparam logic [2:0] RSN_REJECT = 3'd0;
  localparam logic [2:0] RSN_STA    = 3'd1;
  localparam logic [2:0] RSN_BCAST  = 3'd2;
  localparam logic [2:0] RSN_HASH   = 3'd3;
  localparam logic [2:0] RSN_PROM   = 3'd4;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [2:0]              cfg_q;
  logic [DEST_BYTES*8-1:0] sta_q;
  logic [TAB_BITS-1:0]     hash_q;
  logic                    rx_en, promisc, hash_en;

  assign rx_en   = cfg_q[0];
  assign promisc = cfg_q[1];
  assign hash_en = cfg_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sta_q  <= '0;
      hash_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(0)) cfg_q <= wr_data[2:0];
      for (int k = 0; k < STA_WORDS; k++)
        if (wr_addr == ADDR_W'(STA_BASE + k))
          sta_q[(STA_WORDS-1-k)*WORD_W +: WORD_W] <= wr_data;
      for (int k = 0; k < HASH_WORDS; k++)
        if (wr_addr == ADDR_W'(HASH_TOP - k))
          hash_q[k*WORD_W +: WORD_W] <= wr_data;
    end
  end

  logic [CNT_W-1:0] cnt_q, pos;
  logic [31:0]      crc_q, crc_nxt;
  logic             sta_ok_q, bc_ok_q, sta_ok_nxt, bc_ok_nxt;
  logic             step, last, hash_hit;
  logic [7:0]       exp_byte;
  logic [IDX_W-1:0] hidx;
  logic [2:0]       reason;

  assign step       = in_vld && (in_sof || cnt_q != CNT_W'(DEST_BYTES));
  assign pos        = in_sof ? '0 : cnt_q;
  assign last       = step && pos == CNT_W'(DEST_BYTES - 1);
  assign exp_byte   = sta_q[(DEST_BYTES-1-int'(pos))*8 +: 8];
  assign crc_nxt    = crc_byte(in_sof ? 32'hFFFFFFFF : crc_q, in_data);
  assign sta_ok_nxt = (in_sof || sta_ok_q) && in_data == exp_byte;
  assign bc_ok_nxt  = (in_sof || bc_ok_q) && in_data == 8'hFF;
  assign hidx       = crc_nxt[31 -: IDX_W];
  assign hash_hit   = hash_q[hidx];

  always_comb begin
    if (!rx_en)                  reason = RSN_REJECT;
    else if (promisc)            reason = RSN_PROM;
    else if (sta_ok_nxt)         reason = RSN_STA;
    else if (bc_ok_nxt)          reason = RSN_BCAST;
    else if (hash_en && hash_hit) reason = RSN_HASH;
    else                         reason = RSN_REJECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= CNT_W'(DEST_BYTES);
      crc_q    <= '1;
      sta_ok_q <= 1'b0;
      bc_ok_q  <= 1'b0;
    end else if (step) begin
      cnt_q    <= pos + 1'b1;
      crc_q    <= crc_nxt;
      sta_ok_q <= sta_ok_nxt;
      bc_ok_q  <= bc_ok_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= '0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last && reason != RSN_REJECT;
      dec_reason <= last ? reason : RSN_REJECT;
    end
  end
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_vld,
  input logic       rx_en,
  input logic       promisc,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [2:0] dec_reason
);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_vld));
  assert_disabled_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(rx_en)) |-> dec_reason == 3'd0);
  assert_promisc_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(rx_en && promisc)) |-> dec_reason == 3'd4);
  assert_accept_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (dec_reason != 3'd0)));
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_reason == 3'd0));
  assert_reason_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_reason <= 3'd4);
endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .rx_en(rx_en), .promisc(promisc),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA = 48'h0211_2233_4455;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [50:0] VEC [0:11] = '{
    {3'b001, STA},
    {3'b001, BC},
    {3'b001, 48'h0211_2233_4454},
    {3'b011, 48'h1234_5678_9ABC},
    {3'b000, STA},
    {3'b101, 48'h0100_5E00_0001},
    {3'b101, STA},
    {3'b111, BC},
    {3'b001, 48'hFFFF_FFFF_FFFE},
    {3'b101, 48'h0100_5E7F_FFFA},
    {3'b101, 48'h3333_0000_0001},
    {3'b101, 48'hFFFF_FFFF_FFFE}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, in_vld = 0, in_sof = 0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  in_data = '0;
  logic dec_valid, dec_accept;
  logic [2:0] dec_reason;
  logic [63:0] tab;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dest_filter uut (.*);

  function automatic logic [5:0] ref_idx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ d[47 - 8*i - 7 + b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c[31:26];
  endfunction

  function automatic int ref_reason(input logic [2:0] cfg, input logic [47:0] d);
    if (!cfg[0]) return 0;
    if (cfg[1]) return 4;
    if (d == STA) return 1;
    if (d == BC) return 2;
    if (cfg[2] && tab[ref_idx(d)]) return 3;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_tab();
    for (int k = 0; k < 4; k++) reg_wr(7 - k, tab[16*k +: 16]);
  endtask

  task automatic drive(input logic sof, input logic [7:0] b);
    @(negedge clk); in_vld = 1; in_sof = sof; in_data = b;
  endtask

  task automatic frame_check(input string req, input logic [47:0] d, input int exp);
    for (int i = 0; i < 6; i++) drive(i == 0, d[47 - 8*i -: 8]);
    @(negedge clk); in_vld = 0; in_sof = 0;
    chk({req, " dec_valid"}, int'(dec_valid), 1);
    chk({req, " reason"}, int'(dec_reason), exp);
    chk({req, " accept"}, int'(dec_accept), int'(exp != 0));
    @(negedge clk);
    chk({req, " pulse ends"}, int'(dec_valid), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset dec_valid", int'(dec_valid), 0);
    chk("R1 reset reason", int'(dec_reason), 0);
    frame_check("R1 cleared config rejects", BC, 0);

    reg_wr(1, STA[47:32]); reg_wr(2, STA[31:16]); reg_wr(3, STA[15:0]);
    tab = 64'h5AA5_3C3C_0F0F_A5A5;
    load_tab();

    for (int v = 0; v < 12; v++) begin
      logic [2:0] cfg = VEC[v][50:48];
      logic [47:0] d = VEC[v][47:0];
      reg_wr(0, {13'd0, cfg});
      frame_check($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", v), d, ref_reason(cfg, d));
    end

    reg_wr(0, 16'd1);
    for (int i = 0; i < 3; i++) drive(i == 0, 8'hFF);
    @(negedge clk); in_vld = 0;
    chk("R10 no decision on partial", int'(dec_valid), 0);
    frame_check("R10 sof restarts", STA, 1);

    frame_check("R2 broadcast before trailing bytes", BC, 2);
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin
        drive(0, 8'hFF);
        seen += int'(dec_valid);
      end
      @(negedge clk); in_vld = 0;
      seen += int'(dec_valid);
      chk("R2 bytes after sixth ignored", seen, 0);
    end

    for (int i = 0; i < 6; i++) begin
      drive(i == 0, STA[47 - 8*i -: 8]);
      @(negedge clk); in_vld = 0; in_sof = 0;
      if (i < 5) chk("R2 no early decision", int'(dec_valid), 0);
      else chk("R2 decision after gapped bytes", int'(dec_reason), 1);
    end

    begin
      logic [47:0] d = 48'h0100_5E00_00FB;
      logic [5:0] ix = ref_idx(d);
      reg_wr(0, 16'd5);
      tab = '0; tab[ix] = 1'b1;
      load_tab();
      frame_check("R9 R8 single hash bit set", d, 3);
      tab = '1; tab[ix] = 1'b0;
      load_tab();
      frame_check("R9 single hash bit clear", d, 0);
      tab = '1;
      load_tab();
      reg_wr(0, 16'd1);
      frame_check("R7 hash disabled rejects", d, 0);
      reg_wr(0, 16'd0);
      frame_check("R3 disabled station", STA, 0);
    end

    finish_run();
  end
endmodule